// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block sits beside a host bridge and routes each memory request in the legacy area from 0xA0000 to 0xFFFFF. A request can go to system DRAM, to DRAM used as read-only shadow memory, or out to the legacy expansion bus. Outside that area every request goes to DRAM. The routing decision comes from seven programmable attribute bytes, from a system-management window control byte and from a live SMM-active input.

Software programs the bytes through a 32-bit configuration write port. The port takes a dword index, four byte enables and write data. Byte lane n of dword d writes configuration byte 4*d+n. The attribute bytes sit at byte offsets 0x59 to 0x5F, and the window control byte sits at offset 0x72. A write may cover only part of the attribute range. In that case only the enabled bytes inside the range change.

The window control byte has a lock mechanism built as a two-state machine. In state SR_UNLOCKED, writes are accepted. Transition LOCK_SET goes to SR_LOCKED when an accepted write has bit 4 set. In SR_LOCKED the only transition is HOLD, back into SR_LOCKED, until reset returns the machine to SR_UNLOCKED. The request decode is combinational. It therefore follows both the registers and the SMM input in the same cycle.

Top module: `legacy_window_decoder`

## Requirements
- R1: After reset all seven attribute bytes are 0 and the window control byte is 0x02. Every request in 0xA0000 to 0xFFFFF then selects the legacy bus, whatever the SMM input.
- R2: A request whose address is below 0xA0000, or at or above 0x100000, selects DRAM.
- R3: The target output is encoded as follows: 2'b00 is DRAM, 2'b01 is a DRAM read from a read-only segment, and 2'b10 is the legacy bus. The value 2'b11 never appears.
- R4: The 64 KB segment 0xF0000 to 0xFFFFF takes its attribute from bits 5:4 of byte 0x59. Bits 1:0 of that byte have no effect on it.
- R5: Segment i (0 to 11) covers 16 KB starting at 0xC0000 + i*0x4000. Its attribute is bits 1:0 of the low nibble of byte 0x5A + i/2 when i is even, or bits 5:4 of that byte when i is odd.
- R6: Attribute 3 sends reads and writes to DRAM. Attribute 1 sends reads to 2'b01 and writes to the legacy bus. Attributes 0 and 2 send both to the legacy bus.
- R7: The window 0xA0000 to 0xBFFFF selects DRAM when SMM is active and bit 3 of byte 0x72 is set, or when bit 6 of byte 0x72 is set. Otherwise it selects the legacy bus.
- R8: A write updates only the bytes whose lane enable is set. The new value governs requests from the cycle after the write edge, so a write that only partly covers the attribute range leaves the other attribute bytes unchanged.
- R9: A change on the SMM input changes the window decode in the same cycle, with no clock edge needed.
- R10: An accepted write to byte 0x72 with bit 4 set locks the byte and stores bit 6 as 0. Later writes to byte 0x72 are ignored until reset, and the other stored bits are kept.
- R11: Writes to bytes outside 0x59 to 0x5F and 0x72, including writes to dword 0x1C with lane 2 disabled, change no decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index of the configuration write |
| cfg_be | input | 4 | Byte lane enables |
| cfg_wdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| smm_active | input | 1 | Processor is in system-management mode |
| req_addr | input | ADDR_W | Physical address of the request |
| req_write | input | 1 | Request is a write |
| req_tgt | output | 2 | Selected target, encoded as in R3 |

## Verification
The assertions assume that reset is held for at least one clock edge before any request is checked. They also assume that the configuration inputs and SMM input change only between clock edges. The bench drives every input on the falling edge and samples the target output one nanosecond later. The bench waits one rising edge after each write before it samples, which matches the registered effect in R8. To exercise R9, it changes SMM alone and samples without an intervening clock edge.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
    typedef enum logic [1:0] {
        TGT_DRAM = 2'b00,
        TGT_ROM  = 2'b01,
        TGT_BUS  = 2'b10
    } tgt_e;

    typedef enum logic {
        SR_UNLOCKED = 1'b0,
        SR_LOCKED   = 1'b1
    } lock_e;

    localparam int ATTR_BASE   = 8'h59;
    localparam int ATTR_BYTES  = 7;
    localparam int WIN_OFF     = 8'h72;
    localparam logic [7:0] WIN_RST = 8'h02;
    localparam int WIN_SMM_BIT  = 3;
    localparam int WIN_LOCK_BIT = 4;
    localparam int WIN_OPEN_BIT = 6;
endpackage

// File: rtl/lwd_attr_regs.sv
module lwd_attr_regs #(
    parameter int N_BYTES  = 7,
    parameter int BASE_OFF = 8'h59,
    parameter int DW_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [DW_W-1:0]             cfg_dw,
    input  logic [3:0]                  cfg_be,
    input  logic [31:0]                 cfg_wdata,
    output logic [N_BYTES-1:0][7:0]     attr_q
);
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        localparam int OFF  = BASE_OFF + k;
        localparam int DW   = OFF / 4;
        localparam int LANE = OFF % 4;
        logic       hit;
        logic [7:0] byte_q;

        assign hit = cfg_we && (cfg_dw == DW_W'(DW)) && cfg_be[LANE];

        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= 8'h00;
            else if (hit)
                byte_q <= cfg_wdata[8*LANE +: 8];
        end

        assign attr_q[k] = byte_q;
    end
endmodule

// File: rtl/lwd_win_ctl.sv
module lwd_win_ctl
    import lwd_pkg::*;
#(
    parameter int DW_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [DW_W-1:0] cfg_dw,
    input  logic [3:0]      cfg_be,
    input  logic [31:0]     cfg_wdata,
    input  logic            smm_active,
    output logic [7:0]      win_q,
    output logic            locked,
    output logic            win_open
);
    localparam int WDW  = WIN_OFF / 4;
    localparam int LANE = WIN_OFF % 4;

    lock_e      state, nxt;
    logic       hit;
    logic       wr_ok;
    logic [7:0] wr_byte;

    assign hit     = cfg_we && (cfg_dw == DW_W'(WDW)) && cfg_be[LANE];
    assign wr_byte = cfg_wdata[8*LANE +: 8];

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SR_UNLOCKED;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SR_UNLOCKED: if (hit && wr_byte[WIN_LOCK_BIT]) nxt = SR_LOCKED;
            SR_LOCKED:   nxt = SR_LOCKED;
        endcase
    end

    always_comb begin
        wr_ok  = 1'b0;
        locked = 1'b0;
        unique case (state)
            SR_UNLOCKED: wr_ok  = 1'b1;
            SR_LOCKED:   locked = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= WIN_RST;
        else if (hit && wr_ok) begin
            win_q <= wr_byte;
            if (wr_byte[WIN_LOCK_BIT])
                win_q[WIN_OPEN_BIT] <= 1'b0;
        end
    end

    assign win_open = (smm_active && win_q[WIN_SMM_BIT]) ||
                      (win_q[WIN_OPEN_BIT] && !locked);
endmodule

// File: rtl/lwd_seg_decode.sv
module lwd_seg_decode
    import lwd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int N_BYTES = 7
) (
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic [N_BYTES-1:0][7:0] attr_q,
    input  logic                    win_open,
    output logic [1:0]              req_tgt
);
    localparam int HI_W = ADDR_W - 20;

    logic [3:0] blk;
    logic [5:0] seg_full;
    logic [3:0] seg;
    logic [7:0] sel_byte;
    logic [1:0] attr;
    tgt_e       tgt;

    assign blk      = req_addr[19:16];
    assign seg_full = req_addr[19:14] - 6'h30;
    assign seg      = seg_full[3:0];

    always_comb begin
        attr     = 2'b00;
        sel_byte = attr_q[3'(seg[3:1]) + 3'd1];
        tgt      = TGT_DRAM;
        if (req_addr[ADDR_W-1:20] != HI_W'(0) || blk < 4'hA) begin
            tgt = TGT_DRAM;
        end else if (blk <= 4'hB) begin
            tgt = win_open ? TGT_DRAM : TGT_BUS;
        end else begin
            if (blk == 4'hF)
                attr = attr_q[0][5:4];
            else
                attr = seg[0] ? sel_byte[5:4] : sel_byte[1:0];
            unique case (attr)
                2'b11:   tgt = TGT_DRAM;
                2'b01:   tgt = req_write ? TGT_BUS : TGT_ROM;
                default: tgt = TGT_BUS;
            endcase
        end
    end

    assign req_tgt = tgt;
endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
    import lwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DW_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DW_W-1:0]   cfg_dw,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              smm_active,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic [1:0]        req_tgt
);
    logic [ATTR_BYTES-1:0][7:0] attr_q;
    logic [7:0]                 win_q;
    logic                       locked;
    logic                       win_open;

    lwd_attr_regs #(.N_BYTES(ATTR_BYTES), .BASE_OFF(ATTR_BASE), .DW_W(DW_W)) u_attr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .attr_q(attr_q)
    );

    lwd_win_ctl #(.DW_W(DW_W)) u_win (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .smm_active(smm_active),
        .win_q(win_q), .locked(locked), .win_open(win_open)
    );

    lwd_seg_decode #(.ADDR_W(ADDR_W), .N_BYTES(ATTR_BYTES)) u_dec (
        .req_addr(req_addr), .req_write(req_write), .attr_q(attr_q),
        .win_open(win_open), .req_tgt(req_tgt)
    );
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic [1:0]        req_tgt,
    input logic [7:0]        win_q,
    input logic              locked
);
    a_r2_outside_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[ADDR_W-1:20] != '0 || req_addr[19:16] < 4'hA) |-> req_tgt == 2'b00);

    a_r3_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        req_tgt != 2'b11);

    a_r6_ro_write_bus: assert property (@(posedge clk) disable iff (!rst_n)
        req_write |-> req_tgt != 2'b01);

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> locked);

    a_r10_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) && locked) |-> $stable(win_q));

    a_r10_open_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !win_q[6]);
endmodule

bind legacy_window_decoder lwd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_write(req_write),
    .req_tgt(req_tgt), .win_q(win_q), .locked(locked)
);

// File: tb/sim_legacy_window_decoder.sv
module sim_legacy_window_decoder;
    localparam logic [1:0] DRAM = 2'b00, ROM = 2'b01, BUS = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        smm_active = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_tgt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    legacy_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .smm_active(smm_active),
        .req_addr(req_addr), .req_write(req_write), .req_tgt(req_tgt)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
    endtask

    task automatic chk(input logic [31:0] a, input logic w, input logic [1:0] exp,
                       input string req);
        req_addr = a; req_write = w;
        #1;
        n_run++;
        if (req_tgt !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0d actual=%b expected=%b", req, a, w, req_tgt, exp);
        end
    endtask

    task automatic t_reset();
        smm_active = 1'b1;
        chk(32'h000A0000, 0, BUS, "R1");
        chk(32'h000C0000, 0, BUS, "R1");
        chk(32'h000FFFFF, 1, BUS, "R1");
        smm_active = 1'b0;
        chk(32'h0009FFFF, 0, DRAM, "R2");
        chk(32'h00100000, 1, DRAM, "R2");
        chk(32'h800F0000, 0, DRAM, "R2");
    endtask

    task automatic t_fseg();
        wr(6'h16, 4'b0010, 32'h0000_3000);
        chk(32'h000F0000, 0, DRAM, "R4");
        chk(32'h000F8000, 1, DRAM, "R6");
        wr(6'h16, 4'b0010, 32'h0000_1000);
        chk(32'h000F4000, 0, ROM, "R3");
        chk(32'h000F4000, 1, BUS, "R6");
        wr(6'h16, 4'b0010, 32'h0000_0300);
        chk(32'h000F0000, 0, BUS, "R4");
    endtask

    task automatic t_segs();
        wr(6'h16, 4'b0100, 32'h0031_0000);
        chk(32'h000C0000, 0, ROM, "R5");
        chk(32'h000C3FFF, 1, BUS, "R6");
        chk(32'h000C4000, 1, DRAM, "R5");
        wr(6'h16, 4'b1000, 32'h0200_0000);
        chk(32'h000C8000, 0, BUS, "R6");
        wr(6'h17, 4'b1000, 32'h7C00_0000);
        chk(32'h000E8000, 0, BUS, "R5");
        chk(32'h000EC000, 1, DRAM, "R5");
        chk(32'h000EFFFF, 0, DRAM, "R5");
    endtask

    task automatic t_partial();
        wr(6'h16, 4'b1111, 32'h3333_30FF);
        chk(32'h000C0000, 1, DRAM, "R8");
        chk(32'h000CC000, 0, DRAM, "R8");
        chk(32'h000F0000, 0, DRAM, "R8");
        wr(6'h16, 4'b0100, 32'h0000_0000);
        chk(32'h000C0000, 0, BUS, "R8");
        chk(32'h000C4000, 0, BUS, "R8");
        chk(32'h000C8000, 0, DRAM, "R8");
        chk(32'h000F0000, 0, DRAM, "R8");
    endtask

    task automatic t_other();
        wr(6'h15, 4'b1111, 32'hFFFF_FFFF);
        chk(32'h000C0000, 0, BUS, "R11");
        chk(32'h000C8000, 0, DRAM, "R11");
        wr(6'h1C, 4'b1011, 32'hFFFF_FFFF);
        smm_active = 1'b0;
        chk(32'h000A0000, 0, BUS, "R11");
    endtask

    task automatic t_window();
        wr(6'h1C, 4'b0100, 32'h0008_0000);
        smm_active = 1'b0;
        chk(32'h000A0000, 0, BUS, "R7");
        @(negedge clk);
        smm_active = 1'b1;
        chk(32'h000BFFFF, 1, DRAM, "R9");
        smm_active = 1'b0;
        chk(32'h000BFFFF, 1, BUS, "R9");
        wr(6'h1C, 4'b0100, 32'h0040_0000);
        chk(32'h000B0000, 0, DRAM, "R7");
        wr(6'h1C, 4'b0100, 32'h0002_0000);
        chk(32'h000B0000, 0, BUS, "R7");
    endtask

    task automatic t_lock();
        wr(6'h1C, 4'b0100, 32'h0058_0000);
        smm_active = 1'b0;
        chk(32'h000A0000, 0, BUS, "R10");
        smm_active = 1'b1;
        chk(32'h000A0000, 0, DRAM, "R10");
        wr(6'h1C, 4'b0100, 32'h0040_0000);
        smm_active = 1'b0;
        chk(32'h000A0000, 0, BUS, "R10");
        wr(6'h1C, 4'b0100, 32'h0000_0000);
        smm_active = 1'b1;
        chk(32'h000A0000, 0, DRAM, "R10");
        do_reset();
        chk(32'h000A0000, 0, BUS, "R1");
        chk(32'h000C8000, 0, BUS, "R1");
        wr(6'h1C, 4'b0100, 32'h0040_0000);
        smm_active = 1'b0;
        chk(32'h000A0000, 0, DRAM, "R10");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_fseg();
        t_segs();
        t_partial();
        t_other();
        t_window();
        t_lock();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule